// File: doc/BRIEF.md
# Instruction Pre-Decoder

This block looks at one fetched 32-bit instruction word of a small load/store RISC instruction set, together with the address it was fetched from, and describes the instruction for a downstream scheduler or translator. It does not execute anything. The description lists which general registers are read and which are written, whether memory is read or written, and how control flow changes. Control flow covers conditional or unconditional branches, the end of a straight-line run, the number of delay slots, and either a static branch target or a flag that the target is only known at run time. The block also raises a flag when it recognises the encoding.

Instruction memory is a 4 KB window. Every static target is folded into that window: the low 12 bits wrap and bit 12 is always set. Some branches compare against register zero, or compare a register with itself, so their condition is always true. These are reported as unconditional jumps that end the run, with no register reads.

The caller presents a word with a one-cycle strobe. The description appears on registered outputs one clock later, and those outputs hold until the next strobe.

Top module: `insn_predecode`

## Requirements
- R1: When `inValid` is high at a rising edge, all description outputs take the values for that word at that edge, and `outValid` is high for the following cycle. When `inValid` is low, `outValid` falls and every other output holds. After reset every output is zero.
- R2: Any encoding not listed in R3 to R10 gives `recognised`=0, zero masks, zero flags, `delaySlots`=0 and `target`=0. Listed encodings give `recognised`=1.
- R3: Primary opcode (bits 31:26) 0x02 and 0x03 are absolute jumps with `target` = 0x1000 | ((bits 25:0 << 2) & 0xFFF). Both set uncond, end-of-run and one delay slot. Opcode 0x03 also sets write-mask bit 31.
- R4: Opcodes 0x04 to 0x07 and the group at opcode 0x01 (rt field, bits 20:16, equal to 0x00, 0x01, 0x10 or 0x11) are relative branches. Their `target` = 0x1000 | ((pc + 4 + (sign-extended bits 15:0 << 2)) & 0xFFF), with one delay slot.
- R5: Opcode 0x04 with rs (bits 25:21) equal to rt, opcode 0x06 with rs=0, and group 0x01 with rt=0x01 or rt=0x11 and rs=0 are reported as uncond plus end-of-run and read no register. In all other cases the relative branches are cond: opcodes 0x04 and 0x05 read rs and rt, and the rest read rs.
- R6: Group 0x01 with rt=0x10 or rt=0x11 always sets write-mask bit 31.
- R7: Opcode 0x00 has funct field bits 5:0. Funct 0x08 reads rs. Funct 0x09 reads rs and writes rd (bits 15:11). Both set uncond, end-of-run, one delay slot and `dynTarget`. Funct 0x0D sets end-of-run and `dynTarget` with zero delay slots.
- R8: Loads (opcodes 0x20, 0x21, 0x23, 0x24, 0x25, 0x27) read rs, write rt and set `memRead`. Stores (0x28, 0x29, 0x2B) read rs and rt and set `memWrite`. Opcode 0x32 reads rs and sets `memRead`. Opcode 0x3A reads rs and sets `memWrite`.
- R9: Opcodes 0x08 to 0x0E read rs and write rt, and 0x0F writes rt only. Under opcode 0x00, funct 0x00, 0x02 and 0x03 read rt and write rd. Funct 0x04, 0x06, 0x07, 0x20 to 0x27, 0x2A and 0x2B read rs and rt and write rd.
- R10: Opcode 0x10 with rs=0 writes rt, and with rs=4 reads rt. Opcode 0x12 with rs=0 or 2 writes rt, and with rs=4 or 6 reads rt.
- R11: Masks are 32 bits, and bit n stands for register n. A write to register 0 is still shown as mask bit 0.
- R12: `memRead` and `memWrite` are never both high. `condBranch` and `uncondBranch` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Word strobe |
| instr | input | 32 | Instruction word |
| pc | input | 13 | Fetch address of the word |
| outValid | output | 1 | Description updated last edge |
| recognised | output | 1 | Encoding is known |
| readMask | output | 32 | Registers read |
| writeMask | output | 32 | Registers written |
| memRead | output | 1 | Reads data memory |
| memWrite | output | 1 | Writes data memory |
| condBranch | output | 1 | Conditional branch |
| uncondBranch | output | 1 | Unconditional transfer |
| endSeq | output | 1 | Ends a straight-line run |
| delaySlots | output | 2 | Delay-slot count |
| dynTarget | output | 1 | Target known only at run time |
| target | output | 13 | Static target inside the window |

## Verification
Two functions meet in one word. Opcode 0x01 with rt=0x11 and rs=0 is reclassified as an always-taken jump, and its link write to register 31 must still appear in the same output cycle. The same holds for a self-compare on opcode 0x04 whose target wraps past the top of the window. The bench drives these words and compares the whole description vector at once. A link bit lost during reclassification, or a missing bit 12 after the wrap, therefore shows up as a mismatch on that cycle.

// File: rtl/predecode_pkg.sv
package predecode_pkg;
  typedef struct packed {
    logic known;
    logic readRs;
    logic readRt;
    logic writeRt;
    logic writeRd;
    logic writeLink;
    logic memRd;
    logic memWr;
    logic condBr;
    logic uncondBr;
    logic endSeq;
    logic delaySlot;
    logic dynTarget;
    logic absTarget;
    logic relTarget;
  } pdStrobes_t;
endpackage

// File: rtl/predecode_ctrl.sv
module predecode_ctrl
  import predecode_pkg::*;
(
  input  logic [31:0] instr,
  output pdStrobes_t  strobes
);
  logic [5:0] op;
  logic [5:0] funct;
  logic [4:0] rsF;
  logic [4:0] rtF;
  logic       rsZero;
  logic       taken;

  assign op     = instr[31:26];
  assign funct  = instr[5:0];
  assign rsF    = instr[25:21];
  assign rtF    = instr[20:16];
  assign rsZero = (rsF == 5'd0);

  always_comb begin
    strobes = '0;
    taken   = 1'b0;
    case (op)
      6'h00: begin
        case (funct)
          6'h00, 6'h02, 6'h03: begin
            strobes.known = 1'b1; strobes.readRt = 1'b1; strobes.writeRd = 1'b1;
          end
          6'h04, 6'h06, 6'h07, 6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
          6'h26, 6'h27, 6'h2a, 6'h2b: begin
            strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.readRt = 1'b1;
            strobes.writeRd = 1'b1;
          end
          6'h08, 6'h09: begin
            strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.uncondBr = 1'b1;
            strobes.endSeq = 1'b1; strobes.delaySlot = 1'b1; strobes.dynTarget = 1'b1;
            strobes.writeRd = funct[0];
          end
          6'h0d: begin
            strobes.known = 1'b1; strobes.endSeq = 1'b1; strobes.dynTarget = 1'b1;
          end
          default: ;
        endcase
      end
      6'h01: begin
        if (rtF == 5'h00 || rtF == 5'h01 || rtF == 5'h10 || rtF == 5'h11) begin
          taken = rtF[0] && rsZero;
          strobes.known = 1'b1; strobes.delaySlot = 1'b1; strobes.relTarget = 1'b1;
          strobes.writeLink = rtF[4];
          strobes.uncondBr = taken; strobes.endSeq = taken;
          strobes.condBr = !taken; strobes.readRs = !taken;
        end
      end
      6'h02, 6'h03: begin
        strobes.known = 1'b1; strobes.uncondBr = 1'b1; strobes.endSeq = 1'b1;
        strobes.delaySlot = 1'b1; strobes.absTarget = 1'b1; strobes.writeLink = op[0];
      end
      6'h04, 6'h05, 6'h06, 6'h07: begin
        taken = (op == 6'h04 && rsF == rtF) || (op == 6'h06 && rsZero);
        strobes.known = 1'b1; strobes.delaySlot = 1'b1; strobes.relTarget = 1'b1;
        strobes.uncondBr = taken; strobes.endSeq = taken;
        strobes.condBr = !taken; strobes.readRs = !taken;
        strobes.readRt = !taken && !op[1];
      end
      6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0e: begin
        strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.writeRt = 1'b1;
      end
      6'h0f: begin
        strobes.known = 1'b1; strobes.writeRt = 1'b1;
      end
      6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h27: begin
        strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.writeRt = 1'b1;
        strobes.memRd = 1'b1;
      end
      6'h28, 6'h29, 6'h2b: begin
        strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.readRt = 1'b1;
        strobes.memWr = 1'b1;
      end
      6'h32: begin
        strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.memRd = 1'b1;
      end
      6'h3a: begin
        strobes.known = 1'b1; strobes.readRs = 1'b1; strobes.memWr = 1'b1;
      end
      6'h10: begin
        if (rsF == 5'd0) begin strobes.known = 1'b1; strobes.writeRt = 1'b1; end
        if (rsF == 5'd4) begin strobes.known = 1'b1; strobes.readRt = 1'b1; end
      end
      6'h12: begin
        if (rsF == 5'd0 || rsF == 5'd2) begin strobes.known = 1'b1; strobes.writeRt = 1'b1; end
        if (rsF == 5'd4 || rsF == 5'd6) begin strobes.known = 1'b1; strobes.readRt = 1'b1; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/predecode_datapath.sv
module predecode_datapath
  import predecode_pkg::*;
#(
  parameter int REGS  = 32,
  parameter int WIN_W = 12,
  parameter int DS_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [31:0]        instr,
  input  logic [WIN_W:0]     pc,
  input  pdStrobes_t         strobes,
  output logic               outValid,
  output logic               recognised,
  output logic [REGS-1:0]    readMask,
  output logic [REGS-1:0]    writeMask,
  output logic               memRead,
  output logic               memWrite,
  output logic               condBranch,
  output logic               uncondBranch,
  output logic               endSeq,
  output logic [DS_W-1:0]    delaySlots,
  output logic               dynTarget,
  output logic [WIN_W:0]     target
);
  localparam int IDX_W = $clog2(REGS);
  localparam logic [IDX_W-1:0] LINK_REG = IDX_W'(REGS - 1);

  logic [REGS-1:0]  rsHot, rtHot, rdHot, linkHot;
  logic [REGS-1:0]  rdMaskNext, wrMaskNext;
  logic [WIN_W-1:0] wordOff, relSum;
  logic [WIN_W:0]   tgtNext;

  assign rsHot   = REGS'(1) << instr[25:21];
  assign rtHot   = REGS'(1) << instr[20:16];
  assign rdHot   = REGS'(1) << instr[15:11];
  assign linkHot = REGS'(1) << LINK_REG;

  assign rdMaskNext = (strobes.readRs ? rsHot : '0) | (strobes.readRt ? rtHot : '0);
  assign wrMaskNext = (strobes.writeRt ? rtHot : '0) | (strobes.writeRd ? rdHot : '0)
                    | (strobes.writeLink ? linkHot : '0);

  // the low WIN_W bits of (imm << 2) do not depend on sign extension
  assign wordOff = {instr[WIN_W-3:0], 2'b00};
  assign relSum  = pc[WIN_W-1:0] + WIN_W'(4) + wordOff;

  always_comb begin
    tgtNext = '0;
    if (strobes.absTarget) tgtNext = {1'b1, wordOff};
    if (strobes.relTarget) tgtNext = {1'b1, relSum};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; recognised <= 1'b0; readMask <= '0; writeMask <= '0;
      memRead <= 1'b0; memWrite <= 1'b0; condBranch <= 1'b0; uncondBranch <= 1'b0;
      endSeq <= 1'b0; delaySlots <= '0; dynTarget <= 1'b0; target <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        recognised   <= strobes.known;
        readMask     <= rdMaskNext;
        writeMask    <= wrMaskNext;
        memRead      <= strobes.memRd;
        memWrite     <= strobes.memWr;
        condBranch   <= strobes.condBr;
        uncondBranch <= strobes.uncondBr;
        endSeq       <= strobes.endSeq;
        delaySlots   <= DS_W'(strobes.delaySlot);
        dynTarget    <= strobes.dynTarget;
        target       <= tgtNext;
      end
    end
  end

  // R12
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite) && !(condBranch && uncondBranch));

  // R2
  unknown_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !recognised |-> (readMask == '0 && writeMask == '0 && !memRead && !memWrite &&
                     !condBranch && !uncondBranch && !endSeq && delaySlots == '0 &&
                     !dynTarget && target == '0));

  // R1
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(readMask) && $stable(writeMask) && $stable(target)));

  // R4
  win_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condBranch || (uncondBranch && !dynTarget)) |-> target[WIN_W]);

  // R7
  slot_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (delaySlots != '0) |-> (condBranch || uncondBranch));
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import predecode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic [12:0] pc,
  output logic        outValid,
  output logic        recognised,
  output logic [31:0] readMask,
  output logic [31:0] writeMask,
  output logic        memRead,
  output logic        memWrite,
  output logic        condBranch,
  output logic        uncondBranch,
  output logic        endSeq,
  output logic [1:0]  delaySlots,
  output logic        dynTarget,
  output logic [12:0] target
);
  pdStrobes_t strobes;

  predecode_ctrl u_ctrl (
    .instr   (instr),
    .strobes (strobes)
  );

  predecode_datapath #(.REGS(32), .WIN_W(12), .DS_W(2)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .instr        (instr),
    .pc           (pc),
    .strobes      (strobes),
    .outValid     (outValid),
    .recognised   (recognised),
    .readMask     (readMask),
    .writeMask    (writeMask),
    .memRead      (memRead),
    .memWrite     (memWrite),
    .condBranch   (condBranch),
    .uncondBranch (uncondBranch),
    .endSeq       (endSeq),
    .delaySlots   (delaySlots),
    .dynTarget    (dynTarget),
    .target       (target)
  );
endmodule

// File: tb/tb_insn_predecode.sv
`timescale 1ns/1ps
module tb_insn_predecode;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [12:0] pc = 13'h1000;
  logic        outValid, recognised, memRead, memWrite, condBranch, uncondBranch;
  logic        endSeq, dynTarget;
  logic [31:0] readMask, writeMask;
  logic [1:0]  delaySlots;
  logic [12:0] target;

  int checks = 0;
  int failures = 0;

  // flag vector: {rec, memRd, memWr, cond, uncond, endSeq, oneSlot, dyn}
  localparam logic [7:0] REC = 8'h80, MR = 8'h40, MW = 8'h20, CB = 8'h10;
  localparam logic [7:0] UB = 8'h08, ES = 8'h04, DS = 8'h02, DY = 8'h01;
  localparam logic [31:0] R31 = 32'h8000_0000;

  always #2 clk = ~clk;

  insn_predecode dut (.*);

  function automatic logic [31:0] iType(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rType(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  task automatic apply(logic [31:0] w, logic [12:0] addr);
    @(negedge clk);
    instr = w; pc = addr; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectOut(string tag, logic [31:0] rm, logic [31:0] wm, logic [7:0] fl,
                           logic [12:0] tg);
    logic [7:0] act;
    act = {recognised, memRead, memWrite, condBranch, uncondBranch, endSeq,
           delaySlots == 2'd1, dynTarget};
    checks++;
    if (!outValid || readMask !== rm || writeMask !== wm || act !== fl || target !== tg ||
        (!fl[1] && delaySlots !== 2'd0)) begin
      failures++;
      $display("FAIL %s: act v=%0b rd=%h wr=%h fl=%h ds=%0d tg=%h exp rd=%h wr=%h fl=%h tg=%h",
               tag, outValid, readMask, writeMask, act, delaySlots, target, rm, wm, fl, tg);
    end
  endtask

  task automatic testReset();
    checks++;
    if (outValid !== 1'b0 || recognised !== 1'b0 || readMask !== '0 || writeMask !== '0 ||
        target !== '0) begin
      failures++;
      $display("FAIL R1 reset: act v=%0b rec=%0b rd=%h wr=%h tg=%h exp all zero",
               outValid, recognised, readMask, writeMask, target);
    end
  endtask

  task automatic testJumps();
    apply(iType(6'h02, 5'h1f, 5'h1f, 16'hffff), 13'h1000);
    expectOut("R3 jump wrap", 0, 0, REC | UB | ES | DS, 13'h1ffc);
    apply(iType(6'h03, 5'd0, 5'd0, 16'h0010), 13'h1800);
    expectOut("R3 jump link", 0, R31, REC | UB | ES | DS, 13'h1040);
  endtask

  task automatic testRelBranches();
    // R5 self-compare with R4 wrap past window top
    apply(iType(6'h04, 5'd3, 5'd3, 16'h0001), 13'h1ffc);
    expectOut("R5 self eq", 0, 0, REC | UB | ES | DS, 13'h1004);
    apply(iType(6'h04, 5'd2, 5'd5, 16'hfffe), 13'h1000);
    expectOut("R4 back wrap", 32'h24, 0, REC | CB | DS, 13'h1ffc);
    apply(iType(6'h05, 5'd4, 5'd4, 16'h0000), 13'h1010);
    expectOut("R5 ne stays cond", 32'h10, 0, REC | CB | DS, 13'h1014);
    apply(iType(6'h06, 5'd0, 5'd9, 16'h0002), 13'h1020);
    expectOut("R5 le zero", 0, 0, REC | UB | ES | DS, 13'h102c);
    apply(iType(6'h07, 5'd0, 5'd0, 16'h0000), 13'h1020);
    expectOut("R5 gt zero cond", 32'h1, 0, REC | CB | DS, 13'h1024);
  endtask

  task automatic testRegimm();
    apply(iType(6'h01, 5'd0, 5'h11, 16'h0004), 13'h1100);
    expectOut("R6 R5 link taken", 0, R31, REC | UB | ES | DS, 13'h1114);
    apply(iType(6'h01, 5'd7, 5'h10, 16'h0000), 13'h1100);
    expectOut("R6 link cond", 32'h80, R31, REC | CB | DS, 13'h1104);
    apply(iType(6'h01, 5'd0, 5'h00, 16'h0000), 13'h1100);
    expectOut("R5 lt zero cond", 32'h1, 0, REC | CB | DS, 13'h1104);
    apply(iType(6'h01, 5'd9, 5'h01, 16'h0000), 13'h1100);
    expectOut("R5 ge reg cond", 32'h200, 0, REC | CB | DS, 13'h1104);
  endtask

  task automatic testDynamic();
    apply(rType(5'd6, 5'd0, 5'd0, 6'h08), 13'h1000);
    expectOut("R7 reg jump", 32'h40, 0, REC | UB | ES | DS | DY, 0);
    apply(rType(5'd1, 5'd0, 5'd0, 6'h09), 13'h1000);
    expectOut("R7 R11 reg link r0", 32'h2, 32'h1, REC | UB | ES | DS | DY, 0);
    apply(rType(5'd0, 5'd0, 5'd0, 6'h0d), 13'h1000);
    expectOut("R7 break", 0, 0, REC | ES | DY, 0);
  endtask

  task automatic testMemory();
    apply(iType(6'h23, 5'd1, 5'd2, 16'h0), 13'h1000);
    expectOut("R8 load", 32'h2, 32'h4, REC | MR, 0);
    apply(iType(6'h28, 5'd3, 5'd4, 16'h0), 13'h1000);
    expectOut("R8 store", 32'h18, 0, REC | MW, 0);
    apply(iType(6'h32, 5'd5, 5'd6, 16'h0), 13'h1000);
    expectOut("R8 cop load", 32'h20, 0, REC | MR, 0);
    apply(iType(6'h3a, 5'd5, 5'd6, 16'h0), 13'h1000);
    expectOut("R8 cop store", 32'h20, 0, REC | MW, 0);
  endtask

  task automatic testAlu();
    apply(iType(6'h08, 5'd1, 5'd2, 16'h0), 13'h1000);
    expectOut("R9 imm alu", 32'h2, 32'h4, REC, 0);
    apply(iType(6'h0f, 5'd3, 5'd4, 16'h0), 13'h1000);
    expectOut("R9 upper imm", 0, 32'h10, REC, 0);
    apply(rType(5'd0, 5'd5, 5'd6, 6'h00), 13'h1000);
    expectOut("R9 shift imm", 32'h20, 32'h40, REC, 0);
    apply(rType(5'd1, 5'd2, 5'd3, 6'h21), 13'h1000);
    expectOut("R9 reg alu", 32'h6, 32'h8, REC, 0);
  endtask

  task automatic testCop();
    apply(iType(6'h10, 5'd0, 5'd8, 16'h0), 13'h1000);
    expectOut("R10 cp0 from", 0, 32'h100, REC, 0);
    apply(iType(6'h10, 5'd4, 5'd8, 16'h0), 13'h1000);
    expectOut("R10 cp0 to", 32'h100, 0, REC, 0);
    apply(iType(6'h12, 5'd2, 5'd9, 16'h0), 13'h1000);
    expectOut("R10 cp2 from ctl", 0, 32'h200, REC, 0);
    apply(iType(6'h12, 5'd6, 5'd9, 16'h0), 13'h1000);
    expectOut("R10 cp2 to ctl", 32'h200, 0, REC, 0);
  endtask

  task automatic testUnknown();
    apply(iType(6'h22, 5'd1, 5'd2, 16'h0), 13'h1000);
    expectOut("R2 primary", 0, 0, 0, 0);
    apply(rType(5'd1, 5'd2, 5'd3, 6'h01), 13'h1000);
    expectOut("R2 special", 0, 0, 0, 0);
    apply(iType(6'h01, 5'd1, 5'h02, 16'h0), 13'h1000);
    expectOut("R2 regimm", 0, 0, 0, 0);
    apply(iType(6'h10, 5'd2, 5'd2, 16'h0), 13'h1000);
    expectOut("R2 cp0", 0, 0, 0, 0);
  endtask

  task automatic testHold();
    apply(iType(6'h23, 5'd1, 5'd2, 16'h0), 13'h1000);
    @(negedge clk);
    instr = iType(6'h02, 5'd0, 5'd0, 16'h0010);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || readMask !== 32'h2 || writeMask !== 32'h4 || !memRead ||
        target !== 0) begin
      failures++;
      $display("FAIL R1 hold: act v=%0b rd=%h wr=%h mr=%0b tg=%h exp v=0 rd=2 wr=4 mr=1 tg=0",
               outValid, readMask, writeMask, memRead, target);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: act hung exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testJumps();
    testRelBranches();
    testRegimm();
    testDynamic();
    testMemory();
    testAlu();
    testCop();
    testUnknown();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule